// File: doc/BRIEF.md
# DMA Channel Control and Enable

This block holds the control state for a single DMA channel and decides whether the channel may run. A CPU-side register port reads and writes an 8-bit control byte. The byte holds four things: a master run bit, a two-bit destination stepping mode, a block-direction flag and a three-bit trigger-source code. A second enable arrives from a companion register as an input. The channel runs only while both enables are 1.

A non-maskable interrupt pulse drops the master run bit, so the channel stops driving the bus. The channel's destination pointer stays where it was. Software restarts the channel in two steps. First it reads the control byte and sees the run bit at 0. Then it writes the bit to 1. A write of 1 that is not preceded by such a read is dropped. This stops code from re-arming the channel without first noticing that it was halted.

The block also keeps a 24-bit destination pointer. The pointer can be loaded directly. On each completed transfer it moves by the transfer size, but only while the channel is active.

Top module: `dmactl_top`

## Requirements
- R1: Reset, or the `standby` input, clears the control byte to 0x00 and the interlock. On the cycle after that, `chan_active` is 0. The destination pointer is cleared only by reset.
- R2: Bit 6 of `cpu_rdata` always reads 0, whatever value was written to it.
- R3: A write with bit 7 = 1 leaves the run bit at 0 if no read of the control byte has returned bit 7 = 0 since the run bit last became 0.
- R4: After a read that returns bit 7 = 0, a later write with bit 7 = 1 sets the run bit. A write with bit 7 = 0 always clears it.
- R5: A `nmi` pulse clears the run bit and the read interlock. If it arrives in the same cycle as a write of 1 to bit 7, the clear wins.
- R6: `chan_active` is registered. In each cycle it equals (run bit AND `chan_en`) as they stood in the previous cycle.
- R7: The destination stepping mode is set by two bits. With bit 4 = 0 the pointer holds. With bit 4 = 1 and bit 5 = 0 it increments. With bit 4 = 1 and bit 5 = 1 it decrements. The step is 1 when `xfer_word` = 0 and 2 when `xfer_word` = 1. The pointer wraps modulo 2^24.
- R8: A `xfer_done` strobe while `chan_active` = 0 leaves the pointer unchanged. The pointer keeps its value across a suspend and the resume that follows.
- R9: Bit 3 of the written byte drives `blk_dst`, and bits 2..0 drive `src_sel`. Bits 5..0 read back as written.
- R10: `dst_ld` loads `dst_ld_val` into the pointer. A load takes priority over a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Standby entry, clears the control byte |
| cpu_rd | input | 1 | Read strobe for the control byte |
| cpu_wr | input | 1 | Write strobe for the control byte |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Control byte read value |
| chan_en | input | 1 | Per-channel enable from the companion register |
| nmi | input | 1 | Non-maskable interrupt pulse |
| xfer_done | input | 1 | One transfer completed |
| xfer_word | input | 1 | Transfer size: 0 byte, 1 word |
| dst_ld | input | 1 | Load destination pointer |
| dst_ld_val | input | 24 | Pointer load value |
| dst_addr | output | 24 | Destination pointer |
| chan_active | output | 1 | Channel may run (registered) |
| blk_dst | output | 1 | Block area is the destination |
| src_sel | output | 3 | Trigger-source code |

## Verification
The assertions check several rules on every cycle. The run bit never rises without a write of 1. An interrupt always leaves it at 0. `chan_active` follows the previous cycle's enables. The pointer stays still while the channel is idle. The written fields appear on their outputs, and standby clears the byte. What only the bench scenarios can show is the read-then-write ordering of the interlock, the fact that a concurrent interrupt disarms the interlock, the arithmetic of each stepping mode including wrap-around, and resumption from the kept pointer after a suspend.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

    localparam int CTL_W     = 8;
    localparam int RUN_BIT   = 7;
    localparam int FIELD_W   = 6;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    typedef struct packed {
        logic       dst_down;
        logic       dst_move;
        logic       blk_dst;
        logic [2:0] src_sel;
    } ctl_fields_t;

    function automatic step_e decode_step(input ctl_fields_t f);
        if (!f.dst_move)
            return STEP_HOLD;
        else if (f.dst_down)
            return STEP_DEC;
        else
            return STEP_INC;
    endfunction

    function automatic logic [CTL_W-1:0] pack_read(input logic run,
                                                   input ctl_fields_t f);
        return {run, 1'b0, f};
    endfunction

endpackage

// File: rtl/dmactl_reg.sv
module dmactl_reg
    import dmactl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             standby,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [CTL_W-1:0] cpu_wdata,
    input  logic             nmi,
    output logic             run,
    output ctl_fields_t      fields
);
    logic        run_q, armed_q;
    logic        run_d, armed_d;
    ctl_fields_t fields_q, fields_d;

    always_comb begin
        run_d    = run_q;
        armed_d  = armed_q | (cpu_rd & ~run_q);
        fields_d = fields_q;
        if (cpu_wr) begin
            fields_d = ctl_fields_t'(cpu_wdata[FIELD_W-1:0]);
            if (cpu_wdata[RUN_BIT]) begin
                if (!run_q && armed_q) begin
                    run_d   = 1'b1;
                    armed_d = 1'b0;
                end
            end else begin
                run_d = 1'b0;
                if (run_q)
                    armed_d = 1'b0;
            end
        end
        if (nmi) begin
            run_d   = 1'b0;
            armed_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            run_q    <= 1'b0;
            armed_q  <= 1'b0;
            fields_q <= '0;
        end else begin
            run_q    <= run_d;
            armed_q  <= armed_d;
            fields_q <= fields_d;
        end
    end

    assign run    = run_q;
    assign fields = fields_q;
endmodule

// File: rtl/dmactl_gate.sv
module dmactl_gate (
    input  logic clk,
    input  logic rst,
    input  logic standby,
    input  logic run,
    input  logic chan_en,
    output logic active
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst || standby)
            active_q <= 1'b0;
        else
            active_q <= run & chan_en;
    end

    assign active = active_q;
endmodule

// File: rtl/dmactl_addr.sv
module dmactl_addr
    import dmactl_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              done,
    input  logic              active,
    input  logic              word,
    input  step_e             mode,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    logic [ADDR_W-1:0] addr_q, addr_d, step_amt;

    assign step_amt = word ? TWO : ONE;

    always_comb begin
        addr_d = addr_q;
        if (ld) begin
            addr_d = ld_val;
        end else if (done && active) begin
            unique case (mode)
                STEP_INC: addr_d = addr_q + step_amt;
                STEP_DEC: addr_d = addr_q - step_amt;
                default:  addr_d = addr_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else
            addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/dmactl_top.sv
module dmactl_top
    import dmactl_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              chan_en,
    input  logic              nmi,
    input  logic              xfer_done,
    input  logic              xfer_word,
    input  logic              dst_ld,
    input  logic [ADDR_W-1:0] dst_ld_val,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              chan_active,
    output logic              blk_dst,
    output logic [2:0]        src_sel
);
    logic        run;
    ctl_fields_t fields;
    step_e       mode;

    dmactl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .standby   (standby),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .nmi       (nmi),
        .run       (run),
        .fields    (fields)
    );

    dmactl_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .standby (standby),
        .run     (run),
        .chan_en (chan_en),
        .active  (chan_active)
    );

    assign mode = decode_step(fields);

    dmactl_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .ld     (dst_ld),
        .ld_val (dst_ld_val),
        .done   (xfer_done),
        .active (chan_active),
        .word   (xfer_word),
        .mode   (mode),
        .addr   (dst_addr)
    );

    assign cpu_rdata = pack_read(run, fields);
    assign blk_dst   = fields.blk_dst;
    assign src_sel   = fields.src_sel;
endmodule

// File: rtl/dmactl_chk.sv
module dmactl_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              standby,
    input logic              cpu_wr,
    input logic [7:0]        cpu_wdata,
    input logic [7:0]        cpu_rdata,
    input logic              chan_en,
    input logic              nmi,
    input logic              dst_ld,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              chan_active,
    input logic              blk_dst,
    input logic [2:0]        src_sel
);
    logic valid_q;
    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= 1'b1;
    end

    // R1
    standby_clear_chk: assert property (@(posedge clk) disable iff (rst)
        standby |=> (cpu_rdata == 8'h00) && !chan_active);

    // R3
    run_rise_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_q && $rose(cpu_rdata[7])) |-> $past(cpu_wr && cpu_wdata[7]));

    // R5
    nmi_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
        nmi |=> !cpu_rdata[7]);

    // R6
    active_follows_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> chan_active == $past(cpu_rdata[7] && chan_en && !standby));

    // R8
    idle_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !chan_active && !dst_ld) |=> $stable(dst_addr));

    // R9
    field_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_q && $past(cpu_wr && !standby)) |->
            (src_sel == $past(cpu_wdata[2:0]) && blk_dst == $past(cpu_wdata[3])));
endmodule

bind dmactl_top dmactl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .standby     (standby),
    .cpu_wr      (cpu_wr),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (cpu_rdata),
    .chan_en     (chan_en),
    .nmi         (nmi),
    .dst_ld      (dst_ld),
    .dst_addr    (dst_addr),
    .chan_active (chan_active),
    .blk_dst     (blk_dst),
    .src_sel     (src_sel)
);

// File: tb/sim_dmactl_top.sv
module sim_dmactl_top;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst, standby, cpu_rd, cpu_wr, chan_en, nmi;
    logic          xfer_done, xfer_word, dst_ld;
    logic [7:0]    cpu_wdata, cpu_rdata;
    logic [AW-1:0] dst_ld_val, dst_addr;
    logic          chan_active, blk_dst;
    logic [2:0]    src_sel;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // bench model
    logic          m_run, m_armed, m_act;
    logic [5:0]    m_fld;
    logic [AW-1:0] m_addr;

    always #10 clk = ~clk;

    dmactl_top #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .standby(standby), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .chan_en(chan_en), .nmi(nmi), .xfer_done(xfer_done),
        .xfer_word(xfer_word), .dst_ld(dst_ld), .dst_ld_val(dst_ld_val),
        .dst_addr(dst_addr), .chan_active(chan_active), .blk_dst(blk_dst),
        .src_sel(src_sel)
    );

    function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                                input logic [5:0] f,
                                                input logic w);
        logic [AW-1:0] s;
        s = w ? AW'(2) : AW'(1);
        if (!f[4])     return a;
        else if (f[5]) return a - s;
        else           return a + s;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        rst = 0; standby = 0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 8'h00;
        nmi = 0; xfer_done = 0; xfer_word = 0; dst_ld = 0; dst_ld_val = '0;
    endtask

    // apply inputs (already set), advance one cycle, compare all outputs
    task automatic cyc(input string tag);
        logic          n_run, n_armed, n_act;
        logic [5:0]    n_fld;
        logic [AW-1:0] n_addr;
        n_run = m_run; n_armed = m_armed | (cpu_rd & ~m_run); n_fld = m_fld;
        if (cpu_wr) begin
            n_fld = cpu_wdata[5:0];
            if (cpu_wdata[7]) begin
                if (!m_run && m_armed) begin n_run = 1; n_armed = 0; end
            end else begin
                n_run = 0;
                if (m_run) n_armed = 0;
            end
        end
        if (nmi) begin n_run = 0; n_armed = 0; end
        n_act = m_run & chan_en;
        if (dst_ld) n_addr = dst_ld_val;
        else if (xfer_done && m_act) n_addr = step_addr(m_addr, m_fld, xfer_word);
        else n_addr = m_addr;
        if (rst || standby) begin n_run = 0; n_armed = 0; n_fld = 0; n_act = 0; end
        if (rst) n_addr = '0;
        @(posedge clk);
        m_run = n_run; m_armed = n_armed; m_fld = n_fld; m_act = n_act; m_addr = n_addr;
        @(negedge clk);
        check(tag, "rdata", 32'(cpu_rdata), 32'({m_run, 1'b0, m_fld}));
        check(tag, "active", 32'(chan_active), 32'(m_act));
        check(tag, "addr", 32'(dst_addr), 32'(m_addr));
        check(tag, "fields", 32'({blk_dst, src_sel}), 32'(m_fld[3:0]));
        idle();
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        m_run = 0; m_armed = 0; m_act = 0; m_fld = 0; m_addr = 0;
        idle(); chan_en = 0;
        @(negedge clk);
        rst = 1; cyc("R1"); rst = 1; cyc("R1");
        check("R1", "rdata after reset", 32'(cpu_rdata), 32'h00);

        // R2 R3: write all ones without a prior read
        cpu_wr = 1; cpu_wdata = 8'hFF; cyc("R3");
        check("R3", "blind set ignored", 32'(cpu_rdata), 32'h3F);
        check("R2", "bit6 reads zero", 32'(cpu_rdata[6]), 0);
        check("R9", "src_sel", 32'(src_sel), 7);

        // R4: read then set, incrementing mode
        chan_en = 1;
        cpu_rd = 1; cyc("R4");
        cpu_wr = 1; cpu_wdata = 8'h91; cyc("R4");
        check("R4", "run set after read", 32'(cpu_rdata), 32'h91);
        check("R6", "active lags one cycle", 32'(chan_active), 0);
        cyc("R6");
        check("R6", "active", 32'(chan_active), 1);

        // R10 R7
        dst_ld = 1; dst_ld_val = 24'h000100; cyc("R10");
        xfer_done = 1; xfer_word = 1; cyc("R7");
        check("R7", "inc word", 32'(dst_addr), 32'h000102);
        cpu_wr = 1; cpu_wdata = 8'hB1; cyc("R7");
        xfer_done = 1; cyc("R7");
        check("R7", "dec byte", 32'(dst_addr), 32'h000101);
        cpu_wr = 1; cpu_wdata = 8'h81; cyc("R7");
        xfer_done = 1; xfer_word = 1; cyc("R7");
        check("R7", "hold", 32'(dst_addr), 32'h000101);
        cpu_wr = 1; cpu_wdata = 8'h91; cyc("R7");

        // R5: nmi with concurrent write of 1 after a read
        nmi = 1; cpu_wr = 1; cpu_wdata = 8'h91; cpu_rd = 1; cyc("R5");
        check("R5", "nmi clears run", 32'(cpu_rdata[7]), 0);
        cpu_wr = 1; cpu_wdata = 8'h91; cyc("R5");
        check("R5", "interlock disarmed", 32'(cpu_rdata[7]), 0);
        cpu_rd = 1; cyc("R5");
        nmi = 1; cpu_wr = 1; cpu_wdata = 8'h91; cyc("R5");
        check("R5", "clear wins over armed set", 32'(cpu_rdata[7]), 0);
        check("R6", "inactive after nmi", 32'(chan_active), 0);
        xfer_done = 1; cyc("R8");
        check("R8", "done ignored when idle", 32'(dst_addr), 32'h000101);
        cpu_rd = 1; cyc("R8");
        cpu_wr = 1; cpu_wdata = 8'h91; cyc("R8"); cyc("R8");
        xfer_done = 1; cyc("R8");
        check("R8", "resume from kept pointer", 32'(dst_addr), 32'h000102);

        // R7 wraps
        dst_ld = 1; dst_ld_val = 24'hFFFFFF; cyc("R7");
        xfer_done = 1; xfer_word = 1; cyc("R7");
        check("R7", "inc wrap", 32'(dst_addr), 32'h000001);
        cpu_wr = 1; cpu_wdata = 8'hB1; dst_ld = 1; dst_ld_val = '0; cyc("R7");
        xfer_done = 1; cyc("R7");
        check("R7", "dec wrap", 32'(dst_addr), 32'hFFFFFF);

        // R10 priority of load over step
        dst_ld = 1; dst_ld_val = 24'h123456; xfer_done = 1; cyc("R10");
        check("R10", "load wins", 32'(dst_addr), 32'h123456);

        // R6 companion enable low
        chan_en = 0; cyc("R6");
        check("R6", "chan_en low", 32'(chan_active), 0);
        chan_en = 1; cyc("R6");

        // R1 standby
        standby = 1; cyc("R1");
        check("R1", "standby clears", 32'(cpu_rdata), 0);
        check("R1", "standby pointer kept", 32'(dst_addr), 32'h123456);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            chan_en    = ($urandom % 8) != 0;
            cpu_rd     = ($urandom % 4) == 0;
            cpu_wr     = ($urandom % 4) == 0;
            cpu_wdata  = 8'($urandom);
            nmi        = ($urandom % 16) == 0;
            xfer_done  = ($urandom % 2) == 0;
            xfer_word  = 1'($urandom);
            dst_ld     = ($urandom % 32) == 0;
            dst_ld_val = AW'($urandom);
            standby    = ($urandom % 128) == 0;
            cyc("R4_R7_random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule